// File: doc/BRIEF.md
# Layered XOR Diffusion Network

This block is an 18-bit bijective scrambler built from rounds of two-input XOR gates. The 18 bits are split into two lanes of nine: the even lane (bit positions 0, 2, ..., 16) and the odd lane (bit positions 1, 3, ..., 17). Each round toggles every bit of one lane with a bit of the other lane, picked through a round-specific permutation. The source lane passes through that round unchanged, so every round is its own inverse. The encode form runs the rounds forward as a plain feed-forward lattice. The decode form runs the same rounds in reverse order, and each stage consumes bits that earlier stages have already restored. A single corrupted received bit is therefore spread across many output bits.

The block scrambles one word at a time. A mode input selects encode or decode, and a parameter chooses whether the result passes through an output register. Word width, round count and the permutation multiplier are parameters, and each round's permutation is computed from them at elaboration. Framing and checksums belong to neighbouring blocks.

Top module: `diffuse_net`

## Requirements
- R1: With dec_mode=0 the output is the encode mapping. Starting from x=din, rounds r=0..6 are applied in increasing order. In round r, let m_r = 2^(r+1) mod 9 and s = (m_r*k + r) mod 9 for k = 0..8. In an even round, bit 2k becomes x[2k] XOR x[2s+1]. In an odd round, bit 2k+1 becomes x[2k+1] XOR x[2s]. Bits that are not targets of a round keep their value.
- R2: With dec_mode=1 the output is the decode mapping: the same rounds applied in the order r=6 down to 0. Decoding an encoded word returns the original word.
- R3: dec_mode is sampled at the same clock edge as din, and it alone selects between the two mappings for that word, so the mode may change from one word to the next.
- R4: Encoding a decoded word returns the original word, so both mappings are bijections on all 2^18 words.
- R5: The all-zero word maps to the all-zero word in both modes, and any nonzero word maps to a nonzero word.
- R6: With the output register enabled (default), dout takes the mapping of the din and dec_mode present at a rising clock edge, and holds that value until the next rising edge.
- R7: A rising edge with rst=1 sets dout to zero (synchronous reset), whatever din and dec_mode are.
- R8: For every single-bit flip of the input, in either mode, the number of output bits that change equals the count given by the mappings of R1 and R2, and is never zero. The per-bit counts and their totals are reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| dec_mode | input | 1 | 0 selects encode, 1 selects decode |
| din | input | 18 | Word to transform |
| dout | output | 18 | Transformed word |

## Verification
The bench goes after three corner cases. The first is the reversal of round order between the two modes. A design that shares the forward order, or that reverses only the permutation, would still map zero to zero, but it would fail the encode-then-decode and decode-then-encode round trips. The second is the exact source selection in every round, checked with unit vectors and single-bit flips against an independently computed mapping. An off-by-one in the permutation offset or a swapped lane shows up there as a wrong avalanche count or a wrong word. The third is the output timing under reset and mode changes from one word to the next. A combinational leak or a missed clear shows up as dout changing before the edge, or as a nonzero value during reset.

// File: rtl/diffuse_pkg.sv
package diffuse_pkg;

   // Greatest common divisor, used to prove a round permutation is bijective.
   function automatic int unsigned gcd_u(input int unsigned a, input int unsigned b);
      int unsigned x;
      int unsigned y;
      int unsigned t;
      x = a;
      y = b;
      while (y != 0) begin
         t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

   // Multiplier of round r: mul^(r+1) modulo the lane size.
   function automatic int unsigned round_mul(input int unsigned mul,
                                             input int unsigned r,
                                             input int unsigned lane);
      int unsigned m;
      m = 1;
      for (int unsigned i = 0; i <= r; i++) begin
         m = (m * mul) % lane;
      end
      return m;
   endfunction

   // Lane index that feeds target k in round r.
   function automatic int unsigned src_idx(input int unsigned mul,
                                           input int unsigned r,
                                           input int unsigned k,
                                           input int unsigned lane);
      return (round_mul(mul, r, lane) * k + r) % lane;
   endfunction

endpackage

// File: rtl/diffuse_round.sv
module diffuse_round #(
   parameter int unsigned W     = 18,
   parameter int unsigned MUL   = 2,
   parameter int unsigned ROUND = 0
) (
   input  logic [W-1:0] d_i,
   output logic [W-1:0] d_o
);
   localparam int unsigned LANE    = W / 2;
   localparam bit          TGT_ODD = (ROUND % 2) == 1;

   // One XOR level: targets of one lane take a permuted bit of the other lane.
   for (genvar k = 0; k < LANE; k++) begin : g_pair
      localparam int unsigned SRC = diffuse_pkg::src_idx(MUL, ROUND, k, LANE);
      if (TGT_ODD) begin : g_odd
         assign d_o[2*k+1] = d_i[2*k+1] ^ d_i[2*SRC];
         assign d_o[2*k]   = d_i[2*k];
      end else begin : g_even
         assign d_o[2*k]   = d_i[2*k] ^ d_i[2*SRC+1];
         assign d_o[2*k+1] = d_i[2*k+1];
      end
   end

endmodule

// File: rtl/diffuse_chain.sv
module diffuse_chain #(
   parameter int unsigned W       = 18,
   parameter int unsigned ROUNDS  = 7,
   parameter int unsigned MUL     = 2,
   parameter bit          REVERSE = 1'b0
) (
   input  logic [W-1:0] d_i,
   output logic [W-1:0] d_o
);
   logic [ROUNDS:0][W-1:0] stg;

   assign stg[0] = d_i;

   for (genvar g = 0; g < ROUNDS; g++) begin : g_rnd
      localparam int unsigned RI = REVERSE ? (ROUNDS - 1 - g) : g;
      diffuse_round #(
         .W    (W),
         .MUL  (MUL),
         .ROUND(RI)
      ) u_rnd (
         .d_i(stg[g]),
         .d_o(stg[g+1])
      );
   end

   assign d_o = stg[ROUNDS];

endmodule

// File: rtl/diffuse_net.sv
module diffuse_net #(
   parameter int unsigned W       = 18,
   parameter int unsigned ROUNDS  = 7,
   parameter int unsigned MUL     = 2,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         dec_mode,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   localparam int unsigned LANE = W / 2;

   // Elaboration-time parameter checks.
   if ((W % 2) != 0 || W < 4) begin : g_bad_width
      $error("diffuse_net: W must be even and at least 4");
   end
   if (ROUNDS < 1) begin : g_bad_rounds
      $error("diffuse_net: ROUNDS must be at least 1");
   end
   if (diffuse_pkg::gcd_u(MUL, LANE) != 1) begin : g_bad_mul
      $error("diffuse_net: MUL must be coprime to W/2");
   end

   logic [W-1:0] enc_y;
   logic [W-1:0] dec_y;
   logic [W-1:0] sel_y;

   diffuse_chain #(.W(W), .ROUNDS(ROUNDS), .MUL(MUL), .REVERSE(1'b0)) u_enc (
      .d_i(din),
      .d_o(enc_y)
   );

   diffuse_chain #(.W(W), .ROUNDS(ROUNDS), .MUL(MUL), .REVERSE(1'b1)) u_dec (
      .d_i(din),
      .d_o(dec_y)
   );

   assign sel_y = dec_mode ? dec_y : enc_y;

   if (REG_OUT) begin : g_reg
      logic [W-1:0] dout_q;
      always_ff @(posedge clk) begin
         if (rst) dout_q <= '0;
         else     dout_q <= sel_y;
      end
      assign dout = dout_q;

      // R7: reset clears the output at the next edge
      assert_reset_zero_R7: assert property (@(posedge clk) rst |=> (dout == '0));
      // R6: an unchanged input word after a clean cycle leaves the output unchanged
      assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && $stable(din) && $stable(dec_mode)) |=> $stable(dout));
      // R5: nonzero input never yields a zero output word
      assert_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
         (din != '0) |=> (dout != '0));
   end else begin : g_comb
      assign dout = sel_y;
   end

   // Checker chains: run each result through the opposite direction.
   logic [W-1:0] chk_back_y;
   logic [W-1:0] chk_fwd_y;

   diffuse_chain #(.W(W), .ROUNDS(ROUNDS), .MUL(MUL), .REVERSE(1'b1)) u_chk_back (
      .d_i(enc_y),
      .d_o(chk_back_y)
   );

   diffuse_chain #(.W(W), .ROUNDS(ROUNDS), .MUL(MUL), .REVERSE(1'b0)) u_chk_fwd (
      .d_i(dec_y),
      .d_o(chk_fwd_y)
   );

   // R2: decode undoes encode
   assert_inverse_R2: assert property (@(posedge clk) disable iff (rst)
      chk_back_y == din);
   // R4: encode undoes decode
   assert_inverse_R4: assert property (@(posedge clk) disable iff (rst)
      chk_fwd_y == din);
   // R5: zero is the only word the encoder sends to zero
   assert_zero_fixed_R5: assert property (@(posedge clk) disable iff (rst)
      (din == '0) == (enc_y == '0));

endmodule

// File: tb/sim_diffuse_net.sv
`timescale 1ns/1ps
module sim_diffuse_net;
   localparam int W = 18;
   localparam int LANE = 9;
   localparam int ROUNDS = 7;
   localparam int MUL = 2;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         dec_mode = 1'b0;
   logic [W-1:0] din = '0;
   logic [W-1:0] dout;

   int nchk = 0;
   int nerr = 0;
   logic [W-1:0] prev_exp;
   bit have_prev = 0;

   always #2.5 clk = ~clk;

   diffuse_net u0 (
      .clk(clk),
      .rst(rst),
      .dec_mode(dec_mode),
      .din(din),
      .dout(dout)
   );

   // Behavioural model of one round, straight from R1.
   function automatic logic [W-1:0] one_round(input logic [W-1:0] x, input int r);
      logic [W-1:0] y;
      int m;
      y = x;
      m = 1;
      for (int i = 0; i <= r; i++) m = (m * MUL) % LANE;
      for (int k = 0; k < LANE; k++) begin
         int s;
         s = (m * k + r) % LANE;
         if (r % 2 == 0) y[2*k]   = x[2*k]   ^ x[2*s+1];
         else            y[2*k+1] = x[2*k+1] ^ x[2*s];
      end
      return y;
   endfunction

   function automatic logic [W-1:0] model(input logic [W-1:0] x, input logic dm);
      logic [W-1:0] v;
      v = x;
      if (!dm) for (int r = 0; r < ROUNDS; r++) v = one_round(v, r);
      else     for (int r = ROUNDS - 1; r >= 0; r--) v = one_round(v, r);
      return v;
   endfunction

   task automatic check_w(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
      nchk++;
      if (got !== exp) begin
         nerr++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic check_i(input string tag, input int got, input int exp);
      nchk++;
      if (got != exp) begin
         nerr++;
         $display("FAIL %s got %0d expected %0d", tag, got, exp);
      end
   endtask

   // Drive one word at a falling edge, compare the result one falling edge later.
   task automatic cyc(input logic [W-1:0] x, input logic dm, input logic r,
                      input string tag, output logic [W-1:0] got);
      logic [W-1:0] exp;
      din = x;
      dec_mode = dm;
      rst = r;
      #1;
      if (have_prev) check_w("R6 output moved before the edge", dout, prev_exp);
      @(posedge clk);
      @(negedge clk);
      got = dout;
      exp = r ? '0 : model(x, dm);
      check_w(tag, got, exp);
      prev_exp = exp;
      have_prev = 1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired got running expected finished");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      logic [W-1:0] y;
      logic [W-1:0] z;
      logic [W-1:0] x;
      @(negedge clk);

      // Reset state
      for (int i = 0; i < 3; i++) cyc(W'($urandom), 1'($urandom), 1'b1, "R7 reset clears dout", y);

      // Zero maps to zero in both modes
      cyc('0, 1'b0, 1'b0, "R5 zero encode", y);
      check_w("R5 zero encode stays zero", y, '0);
      cyc('0, 1'b1, 1'b0, "R5 zero decode", y);
      check_w("R5 zero decode stays zero", y, '0);

      // Unit vectors through each mapping
      for (int j = 0; j < W; j++) begin
         cyc(W'(1) << j, 1'b0, 1'b0, "R1 unit vector encode", y);
         cyc(W'(1) << j, 1'b1, 1'b0, "R2 unit vector decode", y);
      end

      // Round trips in both orders
      for (int i = 0; i < 400; i++) begin
         x = W'($urandom);
         cyc(x, 1'b0, 1'b0, "R1 encode word", y);
         cyc(y, 1'b1, 1'b0, "R2 decode word", z);
         check_w("R2 decode of encode", z, x);
         cyc(x, 1'b1, 1'b0, "R2 decode word", y);
         cyc(y, 1'b0, 1'b0, "R1 encode word", z);
         check_w("R4 encode of decode", z, x);
      end

      // Mode changing word by word
      for (int i = 0; i < 2000; i++) begin
         cyc(W'($urandom), 1'($urandom), 1'b0, "R3 per-word mode select", y);
      end

      // Avalanche of single-bit flips in both modes
      for (int d = 0; d < 2; d++) begin
         int total;
         logic [W-1:0] yb;
         total = 0;
         x = W'($urandom);
         cyc(x, d[0], 1'b0, "R8 avalanche base", yb);
         for (int j = 0; j < W; j++) begin
            int cnt;
            int ecnt;
            cyc(x ^ (W'(1) << j), d[0], 1'b0, "R8 avalanche flipped", y);
            cnt  = $countones(y ^ yb);
            ecnt = $countones(model(x, d[0]) ^ model(x ^ (W'(1) << j), d[0]));
            check_i("R8 avalanche count", cnt, ecnt);
            nchk++;
            if (cnt == 0) begin
               nerr++;
               $display("FAIL R8 flip of bit %0d got 0 changed bits expected nonzero", j);
            end
            total += cnt;
            $display("avalanche mode=%0d bit=%0d changed=%0d", d, j, cnt);
         end
         $display("avalanche mode=%0d total=%0d", d, total);
      end

      // Reset in the middle of traffic, then recovery
      cyc(W'($urandom) | W'(1), 1'b0, 1'b1, "R7 mid-run reset", y);
      cyc(W'(18'h2A5C3), 1'b1, 1'b0, "R6 first word after reset", y);
      cyc(W'(18'h2A5C3), 1'b1, 1'b0, "R6 repeated word", y);

      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

endmodule